// File: doc/BRIEF.md
# Descriptor-Driven Configuration Transfer Engine

This block moves configuration item bytes between an item store and system memory under the control of a descriptor held in memory. Software places a 16-byte descriptor in memory. It then hands the engine the descriptor's 64-bit address through a small address register. The address goes in either as two 32-bit halves, high half first, or as one 64-bit write. The write that completes the address starts the transfer.

The engine fetches the descriptor one byte at a time. The descriptor is big-endian and holds three fields in this order: a 64-bit target memory address, a 32-bit length and a 32-bit control word. The control word can select a new item before any data moves. It then asks for one of four actions:
- copy item bytes into memory;
- skip over item bytes;
- copy memory bytes into a writable item;
- do nothing.

When the transfer ends, the engine writes a completion word back into the descriptor's control field. The engine keeps the current item key and the byte offset within that item. The item store answers combinationally from these two values.

The memory side is a request stream with valid/ready handshaking plus a response strobe. The engine holds a request, with its address, direction and data, stable until ready is seen high on a clock edge. It then waits for the single matching response before it issues the next request. Responses cannot be back-pressured. The engine has at most one request outstanding.

Top module: `cfg_dma_engine`

## Requirements
- R1: A register write triggers a transfer only in two legal forms. The first is 4 bytes at offset 4, which ORs the data into the low half of the stored address. The second is 8 bytes at offset 0, which supplies the whole address. A 4-byte write at offset 0 loads the high half of the stored address and zeroes its low half, and it does not trigger. Every other size and offset is ignored. While `busy` is high, every register write is ignored.
- R2: At the trigger, the stored address is cleared to zero. A later single low-half write therefore addresses a descriptor below 4 GiB.
- R3: `reg_rdata` returns a slice of the constant 0x51454D5520434647, treated as 8 big-endian bytes. The slice is `reg_size` bytes starting at byte `reg_off`, right-aligned. It is zero when the slice would pass byte 7.
- R4: The descriptor is fetched with 16 byte reads at ascending addresses. Bytes 0-7 are the target address, bytes 8-11 are the length and bytes 12-15 are the control word, each most significant byte first.
- R5: The control bits are: error 0x01, read 0x02, skip 0x04, select 0x08 and write 0x10. When select is set, the item key becomes control[31:16] and the item offset becomes 0 before any data moves, and `item_sel` pulses.
- R6: Read has priority over write, and write has priority over skip. If none of the three bits is set, the length is treated as zero and no data moves.
- R7: A read writes the item byte at the current offset to the target address, then advances the address and the offset. Once the item is absent or exhausted, each remaining byte is written as 0x00 and the offset stays where it is.
- R8: A skip advances the offset and the address by the smaller of the remaining length and the bytes left in the item. It then discards whatever length remains, and memory is not touched.
- R9: A write sets the error bit and moves no bytes in three cases: the item is absent or exhausted, the item is not writable, or the remaining length exceeds the bytes left in the item. Otherwise each memory byte is stored into the item at the current offset.
- R10: An error response ends the transfer with the error bit set. The byte that failed does not advance the address, the offset or the remaining length.
- R11: The engine writes the completion word as 4 big-endian bytes at descriptor address + 12. The word is 0 on success and 1 on error. If the descriptor fetch fails, the word is 1.
- R12: A memory request with `mem_req_valid` high and `mem_req_ready` low keeps its address, direction and data unchanged in the next cycle.
- R13: `busy` rises only in the cycle after a trigger and falls after the last write-back response. While `busy` is low, no memory request and no item write is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Address register write strobe |
| reg_off | input | 3 | Byte offset of the register access |
| reg_size | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| reg_wdata | input | 64 | Write data, right-aligned |
| reg_rdata | output | 64 | Signature slice for the given offset and size |
| busy | output | 1 | Transfer in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_req_addr | output | 64 | Byte address |
| mem_req_wdata | output | 8 | Write byte |
| mem_rsp_valid | input | 1 | Response for the outstanding request |
| mem_rsp_err | input | 1 | Response reports an access error |
| mem_rsp_rdata | input | 8 | Read byte |
| item_sel | output | 1 | One-cycle pulse when a new item is selected |
| item_key | output | 16 | Current item key |
| item_off | output | 32 | Current byte offset within the item |
| item_present | input | 1 | The key names an existing item |
| item_len | input | 32 | Length of the current item in bytes |
| item_writable | input | 1 | The current item accepts writes |
| item_rdata | input | 8 | Item byte at the current offset |
| item_wr | output | 1 | Store `item_wdata` at the current key and offset |
| item_wdata | output | 8 | Byte to store into the item |

## Verification
Two functions can land in the same cycle: a new trigger write and completion of the write-back, at the edge where the last write-back response is taken. The bench provokes this by re-issuing a legal 64-bit trigger on every cycle of a transfer, up to and including the final response cycle. It then checks three things:
- the memory and item images match the reference;
- `busy` stays low afterwards;
- no new descriptor fetch appears.

Random memory stalls move the response cycle around, which varies the alignment between the trigger writes and the final response.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  localparam int ADDR_W = 64;
  localparam int LEN_W  = 32;
  localparam int KEY_W  = 16;
  localparam int BYTE_W = 8;
  localparam int DESC_BYTES = 16;
  localparam int CNT_W  = $clog2(DESC_BYTES);
  localparam int DESC_W = DESC_BYTES * BYTE_W;
  localparam int CTL_OFS = 12;
  localparam logic [63:0] SIGNATURE = 64'h5145_4D55_2043_4647;

  localparam int BIT_ERR  = 0;
  localparam int BIT_RD   = 1;
  localparam int BIT_SKIP = 2;
  localparam int BIT_SEL  = 3;
  localparam int BIT_WR   = 4;

  typedef enum logic [1:0] {MD_NONE, MD_READ, MD_WRITE, MD_SKIP} mode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FREQ, ST_FRSP, ST_DEC, ST_MREQ, ST_MRSP, ST_WREQ, ST_WRSP
  } state_t;
endpackage

// File: rtl/cfg_dma_regs.sv
module cfg_dma_regs
  import cfg_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_off,
  input  logic [3:0]        reg_size,
  input  logic [63:0]       reg_wdata,
  input  logic              busy,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr,
  output logic [63:0]       reg_rdata
);
  logic [ADDR_W-1:0] addr_q;
  logic wr_hi, wr_lo, wr_full;

  assign wr_hi   = reg_wr && !busy && reg_size == 4'd4 && reg_off == 3'd0;
  assign wr_lo   = reg_wr && !busy && reg_size == 4'd4 && reg_off == 3'd4;
  assign wr_full = reg_wr && !busy && reg_size == 4'd8 && reg_off == 3'd0;

  assign start      = wr_lo || wr_full;
  assign start_addr = wr_full ? reg_wdata : (addr_q | {32'd0, reg_wdata[31:0]});

  always_ff @(posedge clk) begin
    if (!rst_n)       addr_q <= '0;
    else if (start)   addr_q <= '0;
    else if (wr_hi)   addr_q <= {reg_wdata[31:0], 32'd0};
  end

  // signature slice, big-endian byte order
  always_comb begin
    int unsigned last;
    last = 32'(reg_off) + 32'(reg_size);
    reg_rdata = '0;
    if (reg_size != 4'd0 && last <= 8) begin
      reg_rdata = SIGNATURE >> (8 * (8 - last));
      if (reg_size != 4'd8)
        reg_rdata = reg_rdata & ((64'd1 << (8 * 32'(reg_size))) - 64'd1);
    end
  end

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (addr_q == '0));
  assert_busy_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(addr_q));
endmodule

// File: rtl/cfg_dma_step.sv
module cfg_dma_step
  import cfg_dma_pkg::*;
(
  input  logic             present,
  input  logic [LEN_W-1:0] len,
  input  logic [LEN_W-1:0] off,
  input  logic [LEN_W-1:0] rem,
  output logic             exhausted,
  output logic [LEN_W-1:0] avail,
  output logic [LEN_W-1:0] chunk
);
  assign exhausted = !present || (off >= len);
  assign avail     = exhausted ? '0 : (len - off);
  assign chunk     = (rem < avail) ? rem : avail;
endmodule

// File: rtl/cfg_dma_core.sv
module cfg_dma_core
  import cfg_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BYTE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [BYTE_W-1:0] mem_rsp_rdata,
  output logic              item_sel,
  output logic [KEY_W-1:0]  item_key,
  output logic [LEN_W-1:0]  item_off,
  input  logic              item_present,
  input  logic [LEN_W-1:0]  item_len,
  input  logic              item_writable,
  input  logic [BYTE_W-1:0] item_rdata,
  output logic              item_wr,
  output logic [BYTE_W-1:0] item_wdata
);
  state_t st_q;
  mode_t  mode_q;
  logic [ADDR_W-1:0] base_q, maddr_q;
  logic [DESC_W-BYTE_W-1:0] desc_q;
  logic [DESC_W-1:0] nd;
  logic [31:0] ctl;
  logic [LEN_W-1:0] rem_q, off_q;
  logic [KEY_W-1:0] key_q;
  logic [CNT_W-1:0] cnt_q;
  logic err_q, sel_q;
  logic exhausted;
  logic [LEN_W-1:0] avail, chunk;

  cfg_dma_step u_step (
    .present(item_present), .len(item_len), .off(off_q), .rem(rem_q),
    .exhausted(exhausted), .avail(avail), .chunk(chunk)
  );

  assign nd  = {desc_q, mem_rsp_rdata};
  assign ctl = nd[31:0];

  assign busy      = (st_q != ST_IDLE);
  assign item_sel  = sel_q;
  assign item_key  = key_q;
  assign item_off  = off_q;
  assign item_wr   = (st_q == ST_MRSP) && mem_rsp_valid && !mem_rsp_err && (mode_q == MD_WRITE);
  assign item_wdata = mem_rsp_rdata;

  always_comb begin
    mem_req_valid = 1'b0;
    mem_req_we    = 1'b0;
    mem_req_addr  = '0;
    mem_req_wdata = '0;
    case (st_q)
      ST_FREQ: begin
        mem_req_valid = 1'b1;
        mem_req_addr  = base_q + ADDR_W'(cnt_q);
      end
      ST_MREQ: begin
        mem_req_valid = 1'b1;
        mem_req_we    = (mode_q == MD_READ);
        mem_req_addr  = maddr_q;
        mem_req_wdata = exhausted ? '0 : item_rdata;
      end
      ST_WREQ: begin
        mem_req_valid = 1'b1;
        mem_req_we    = 1'b1;
        mem_req_addr  = base_q + ADDR_W'(CTL_OFS) + ADDR_W'(cnt_q);
        mem_req_wdata = (cnt_q == CNT_W'(3)) ? {7'd0, err_q} : '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; mode_q <= MD_NONE; base_q <= '0; maddr_q <= '0;
      desc_q <= '0; rem_q <= '0; off_q <= '0; key_q <= '0; cnt_q <= '0;
      err_q <= 1'b0; sel_q <= 1'b0;
    end else begin
      sel_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          base_q <= start_addr; cnt_q <= '0; err_q <= 1'b0; st_q <= ST_FREQ;
        end
        ST_FREQ: if (mem_req_ready) st_q <= ST_FRSP;
        ST_FRSP: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            err_q <= 1'b1; cnt_q <= '0; st_q <= ST_WREQ;
          end else if (cnt_q == CNT_W'(DESC_BYTES - 1)) begin
            maddr_q <= nd[127:64];
            if (ctl[BIT_SEL]) begin
              key_q <= ctl[31:16]; off_q <= '0; sel_q <= 1'b1;
            end
            if (ctl[BIT_RD])        begin mode_q <= MD_READ;  rem_q <= nd[63:32]; end
            else if (ctl[BIT_WR])   begin mode_q <= MD_WRITE; rem_q <= nd[63:32]; end
            else if (ctl[BIT_SKIP]) begin mode_q <= MD_SKIP;  rem_q <= nd[63:32]; end
            else                    begin mode_q <= MD_NONE;  rem_q <= '0; end
            st_q <= ST_DEC;
          end else begin
            desc_q <= nd[DESC_W-BYTE_W-1:0];
            cnt_q  <= cnt_q + 1'b1;
            st_q   <= ST_FREQ;
          end
          if (!mem_rsp_err) desc_q <= nd[DESC_W-BYTE_W-1:0];
        end
        ST_DEC: begin
          if (err_q || rem_q == '0) begin
            cnt_q <= '0; st_q <= ST_WREQ;
          end else begin
            case (mode_q)
              MD_SKIP: begin
                if (exhausted) rem_q <= '0;
                else begin
                  off_q   <= off_q + chunk;
                  maddr_q <= maddr_q + ADDR_W'(chunk);
                  rem_q   <= rem_q - chunk;
                end
              end
              MD_WRITE: begin
                if (!item_writable || exhausted || rem_q > avail) err_q <= 1'b1;
                else st_q <= ST_MREQ;
              end
              default: st_q <= ST_MREQ;
            endcase
          end
        end
        ST_MREQ: if (mem_req_ready) st_q <= ST_MRSP;
        ST_MRSP: if (mem_rsp_valid) begin
          if (mem_rsp_err) err_q <= 1'b1;
          else begin
            maddr_q <= maddr_q + 1'b1;
            rem_q   <= rem_q - 1'b1;
            if (!exhausted) off_q <= off_q + 1'b1;
          end
          st_q <= ST_DEC;
        end
        ST_WREQ: if (mem_req_ready) st_q <= ST_WRSP;
        ST_WRSP: if (mem_rsp_valid) begin
          if (cnt_q == CNT_W'(3)) st_q <= ST_IDLE;
          else begin cnt_q <= cnt_q + 1'b1; st_q <= ST_WREQ; end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req_valid && !item_wr));
  assert_busy_start_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_item_wr_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
    item_wr |-> (item_writable && item_present));
  assert_sel_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    item_sel |-> (item_off == '0));
endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine
  import cfg_dma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_off,
  input  logic [3:0]        reg_size,
  input  logic [63:0]       reg_wdata,
  output logic [63:0]       reg_rdata,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [BYTE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic              mem_rsp_err,
  input  logic [BYTE_W-1:0] mem_rsp_rdata,
  output logic              item_sel,
  output logic [KEY_W-1:0]  item_key,
  output logic [LEN_W-1:0]  item_off,
  input  logic              item_present,
  input  logic [LEN_W-1:0]  item_len,
  input  logic              item_writable,
  input  logic [BYTE_W-1:0] item_rdata,
  output logic              item_wr,
  output logic [BYTE_W-1:0] item_wdata
);
  logic start;
  logic [ADDR_W-1:0] start_addr;

  cfg_dma_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
    .reg_size(reg_size), .reg_wdata(reg_wdata), .busy(busy),
    .start(start), .start_addr(start_addr), .reg_rdata(reg_rdata)
  );

  cfg_dma_core u_core (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata),
    .item_sel(item_sel), .item_key(item_key), .item_off(item_off),
    .item_present(item_present), .item_len(item_len),
    .item_writable(item_writable), .item_rdata(item_rdata),
    .item_wr(item_wr), .item_wdata(item_wdata)
  );
endmodule

// File: tb/sim_cfg_dma_engine.sv
module sim_cfg_dma_engine;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_off = '0;
  logic [3:0] reg_size = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic busy;
  logic mem_req_valid, mem_req_we;
  logic mem_req_ready = 1'b1;
  logic [63:0] mem_req_addr;
  logic [7:0] mem_req_wdata;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [7:0] mem_rsp_rdata = '0;
  logic item_sel;
  logic [15:0] item_key;
  logic [31:0] item_off;
  logic item_present, item_writable;
  logic [31:0] item_len;
  logic [7:0] item_rdata;
  logic item_wr;
  logic [7:0] item_wdata;

  cfg_dma_engine u0 (.*);

  localparam logic [63:0] SIG = 64'h5145_4D55_2043_4647;
  localparam logic [31:0] C_RD = 32'h02, C_SKIP = 32'h04, C_SEL = 32'h08, C_WR = 32'h10;

  logic [7:0] mem [0:511];
  logic [7:0] exp_mem [0:511];
  logic [7:0] itm [0:127];
  logic [7:0] exp_itm [0:127];
  int ilen [0:3] = '{4, 12, 0, 20};
  bit iwrok [0:3] = '{1'b0, 1'b1, 1'b1, 1'b1};
  logic [63:0] bad_rd_lo = 64'd1, bad_rd_hi = 64'd0;
  logic [63:0] bad_wr_lo = 64'd1, bad_wr_hi = 64'd0;
  logic [63:0] first_addr = '0;
  bit first_cap = 1'b0;
  int ekey = 0, eoff = 0;
  bit eerr;
  int n_chk = 0, n_bad = 0;
  bit rst_done = 1'b0;

  function automatic bit rd_bad(logic [63:0] a);
    return (a[63:9] != 0) || (a >= bad_rd_lo && a <= bad_rd_hi);
  endfunction
  function automatic bit wr_bad(logic [63:0] a);
    return (a[63:9] != 0) || (a >= bad_wr_lo && a <= bad_wr_hi);
  endfunction

  // memory model: one-cycle response after handshake
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      if (!first_cap) begin first_addr <= mem_req_addr; first_cap <= 1'b1; end
      mem_rsp_valid <= 1'b1;
      if (mem_req_we) begin
        mem_rsp_err <= wr_bad(mem_req_addr);
        if (!wr_bad(mem_req_addr)) mem[mem_req_addr[8:0]] <= mem_req_wdata;
      end else begin
        mem_rsp_err   <= rd_bad(mem_req_addr);
        mem_rsp_rdata <= mem[mem_req_addr[8:0]];
      end
    end
  end
  always @(negedge clk) mem_req_ready <= rst_done ? (($urandom % 4) != 0) : 1'b1;

  // item store model
  always_comb begin
    item_present  = item_key < 16'd4;
    item_len      = item_present ? 32'(ilen[item_key[1:0]]) : 32'd0;
    item_writable = item_present && iwrok[item_key[1:0]];
    item_rdata    = itm[{item_key[1:0], item_off[4:0]}];
  end
  always @(posedge clk) if (item_wr) itm[{item_key[1:0], item_off[4:0]}] <= item_wdata;

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
    $finish;
  end

  task automatic reg_write(logic [2:0] off, logic [3:0] size, logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_off = off; reg_size = size; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic put_desc(logic [63:0] da, logic [63:0] ta, logic [31:0] len, logic [31:0] ctl);
    logic [127:0] d;
    d = {ta, len, ctl};
    for (int i = 0; i < 16; i++) mem[da[8:0] + 9'(i)] = d[127 - 8*i -: 8];
  endtask

  // reference behaviour from the requirements
  task automatic ref_run(logic [63:0] da);
    logic [127:0] d;
    logic [63:0] a;
    logic [31:0] rem, ctl;
    int mode;
    bit ferr, exh;
    int avail, c;
    ferr = 0; eerr = 0; d = '0;
    for (int i = 0; i < 16; i++) begin
      if (!ferr) begin
        if (rd_bad(da + 64'(i))) ferr = 1;
        else d = {d[119:0], exp_mem[9'(da + 64'(i))]};
      end
    end
    if (ferr) eerr = 1;
    else begin
      a = d[127:64]; rem = d[63:32]; ctl = d[31:0];
      if (ctl[3]) begin ekey = int'(ctl[31:16]); eoff = 0; end
      if (ctl[1]) mode = 1; else if (ctl[4]) mode = 2; else if (ctl[2]) mode = 3;
      else begin mode = 0; rem = 0; end
      while (rem != 0 && !eerr) begin
        exh = (ekey >= 4) || (eoff >= ilen[ekey % 4]);
        avail = exh ? 0 : ilen[ekey % 4] - eoff;
        if (mode == 3) begin
          if (exh) rem = 0;
          else begin
            c = (int'(rem) < avail) ? int'(rem) : avail;
            eoff += c; a += 64'(c); rem -= 32'(c);
          end
        end else if (mode == 2) begin
          if (exh || !iwrok[ekey % 4] || int'(rem) > avail) eerr = 1;
          else if (rd_bad(a)) eerr = 1;
          else begin
            exp_itm[(ekey % 4) * 32 + eoff] = exp_mem[a[8:0]];
            eoff++; a++; rem--;
          end
        end else begin
          if (wr_bad(a)) eerr = 1;
          else begin
            exp_mem[a[8:0]] = exh ? 8'h00 : exp_itm[(ekey % 4) * 32 + eoff];
            if (!exh) eoff++;
            a++; rem--;
          end
        end
      end
    end
    for (int i = 0; i < 4; i++)
      if (!wr_bad(da + 64'(12 + i))) exp_mem[9'(da + 64'(12 + i))] = (i == 3) ? {7'd0, eerr} : 8'h00;
  endtask

  task automatic wait_idle(string tag, bit poke);
    int n;
    n = 0;
    @(negedge clk);
    while (busy && n < 20000) begin
      if (poke) begin reg_wr = 1'b1; reg_off = 3'd0; reg_size = 4'd8; reg_wdata = 64'h0A0; end
      @(negedge clk);
      n++;
    end
    reg_wr = 1'b0;
    chk(!busy, tag, "transfer ends", {63'd0, busy}, 64'd0);
  endtask

  task automatic do_xfer(string tag, logic [63:0] da, bit split, bit poke, bit chk_ctl);
    int nm;
    logic [31:0] got;
    for (int i = 0; i < 512; i++) exp_mem[i] = mem[i];
    for (int i = 0; i < 128; i++) exp_itm[i] = itm[i];
    ref_run(da);
    first_cap = 1'b0;
    if (split) begin
      reg_write(3'd0, 4'd4, {32'd0, da[63:32]});
      reg_write(3'd4, 4'd4, {32'd0, da[31:0]});
    end else reg_write(3'd0, 4'd8, da);
    wait_idle(tag, poke);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req_valid, tag, "no restart after late trigger", {63'd0, busy}, 64'd0);
    end
    if (chk_ctl) begin
      got = {mem[9'(da + 12)], mem[9'(da + 13)], mem[9'(da + 14)], mem[9'(da + 15)]};
      chk(got == {31'd0, eerr}, "R11", {tag, " completion word"}, 64'(got), 64'(eerr));
    end
    nm = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) nm++;
    chk(nm == 0, tag, "memory image mismatching bytes", 64'(nm), 64'd0);
    nm = 0;
    for (int i = 0; i < 128; i++) if (itm[i] !== exp_itm[i]) nm++;
    chk(nm == 0, tag, "item image mismatching bytes", 64'(nm), 64'd0);
    bad_rd_lo = 64'd1; bad_rd_hi = 64'd0; bad_wr_lo = 64'd1; bad_wr_hi = 64'd0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 512; i++) mem[i] = 8'($urandom);
    for (int i = 0; i < 128; i++) itm[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rst_done = 1'b1;
    @(negedge clk);

    // reset state
    chk(!busy && !mem_req_valid, "R13", "reset idle", {62'd0, busy, mem_req_valid}, 64'd0);
    chk(item_key == 16'd0 && item_off == 32'd0, "R5", "reset item position", {item_key, item_off}, 64'd0);

    // R3 signature slices
    reg_off = 3'd0; reg_size = 4'd8; #1;
    chk(reg_rdata == SIG, "R3", "8 bytes at 0", reg_rdata, SIG);
    reg_off = 3'd4; reg_size = 4'd4; #1;
    chk(reg_rdata == 64'h20434647, "R3", "4 bytes at 4", reg_rdata, 64'h20434647);
    reg_off = 3'd2; reg_size = 4'd2; #1;
    chk(reg_rdata == 64'h4D55, "R3", "2 bytes at 2", reg_rdata, 64'h4D55);
    reg_off = 3'd0; reg_size = 4'd1; #1;
    chk(reg_rdata == 64'h51, "R3", "1 byte at 0", reg_rdata, 64'h51);
    reg_off = 3'd6; reg_size = 4'd4; #1;
    chk(reg_rdata == 64'h0, "R3", "slice past end", reg_rdata, 64'h0);

    // R1 illegal forms and high half alone do not trigger
    reg_write(3'd0, 4'd2, 64'h40);
    reg_write(3'd2, 4'd4, 64'h40);
    reg_write(3'd4, 4'd8, 64'h40);
    reg_write(3'd0, 4'd4, 64'h0);
    @(negedge clk);
    chk(!busy, "R1", "no trigger from illegal or high-half write", {63'd0, busy}, 64'd0);

    // R2 / R4: composed address, then cleared
    put_desc(64'h40, 64'h100, 32'd0, 32'd0);
    do_xfer("R4", 64'h1_0000_0040, 1'b1, 1'b0, 1'b0);
    chk(first_addr == 64'h1_0000_0040, "R4", "fetch from composed address", first_addr, 64'h1_0000_0040);
    first_cap = 1'b0;
    reg_write(3'd4, 4'd4, 64'h40);
    wait_idle("R2", 1'b0);
    chk(first_addr == 64'h40, "R2", "address cleared after trigger", first_addr, 64'h40);

    // R11 fetch failure
    put_desc(64'h20, 64'h100, 32'd4, C_RD);
    bad_rd_lo = 64'h25; bad_rd_hi = 64'h25;
    do_xfer("R11", 64'h20, 1'b0, 1'b0, 1'b1);

    // R7 read past item end with select of key 3
    put_desc(64'h00, 64'h120, 32'd30, C_RD | C_SEL | (32'd3 << 16));
    do_xfer("R7", 64'h00, 1'b0, 1'b0, 1'b1);
    // R7 read of absent key 5
    put_desc(64'h10, 64'h150, 32'd6, C_RD | C_SEL | (32'd5 << 16));
    do_xfer("R7", 64'h10, 1'b0, 1'b0, 1'b1);

    // R9 write to read-only key 0, overlong write to key 1, good write
    put_desc(64'h30, 64'h160, 32'd2, C_WR | C_SEL);
    do_xfer("R9", 64'h30, 1'b1, 1'b0, 1'b1);
    put_desc(64'h30, 64'h160, 32'd13, C_WR | C_SEL | (32'd1 << 16));
    do_xfer("R9", 64'h30, 1'b0, 1'b0, 1'b1);
    put_desc(64'h30, 64'h160, 32'd12, C_WR | C_SEL | (32'd1 << 16));
    do_xfer("R9", 64'h30, 1'b0, 1'b0, 1'b1);

    // R8 skip then read remainder
    put_desc(64'h50, 64'h100, 32'd5, C_SKIP | C_SEL | (32'd3 << 16));
    do_xfer("R8", 64'h50, 1'b0, 1'b0, 1'b1);
    put_desc(64'h50, 64'h180, 32'd20, C_RD);
    do_xfer("R8", 64'h50, 1'b0, 1'b0, 1'b1);

    // R6 read beats write; no action bit
    put_desc(64'h60, 64'h190, 32'd4, C_RD | C_WR | C_SKIP | C_SEL | (32'd1 << 16));
    do_xfer("R6", 64'h60, 1'b0, 1'b0, 1'b1);
    put_desc(64'h60, 64'h190, 32'd9, C_SEL | (32'd1 << 16));
    do_xfer("R6", 64'h60, 1'b0, 1'b0, 1'b1);

    // R10 error mid read
    put_desc(64'h70, 64'h1A0, 32'd8, C_RD | C_SEL | (32'd3 << 16));
    bad_wr_lo = 64'h1A3; bad_wr_hi = 64'h1A3;
    do_xfer("R10", 64'h70, 1'b0, 1'b0, 1'b1);

    // R13 / R1: trigger attempts during and at the end of a transfer
    put_desc(64'h80, 64'h1C0, 32'd6, C_RD | C_SEL | (32'd1 << 16));
    put_desc(64'hA0, 64'h100, 32'd20, C_WR | C_SEL | (32'd3 << 16));
    do_xfer("R13", 64'h80, 1'b0, 1'b1, 1'b1);

    // random mix
    for (int t = 0; t < 60; t++) begin
      logic [63:0] da, ta;
      logic [31:0] ctl, len;
      int m;
      string tag;
      da  = 64'(16 * ($urandom % 12));
      ta  = 64'h100 + 64'($urandom % 200);
      len = 32'($urandom % 26);
      m   = $urandom % 5;
      case (m)
        0: begin ctl = C_RD; tag = "R7"; end
        1: begin ctl = C_WR; tag = "R9"; end
        2: begin ctl = C_SKIP; tag = "R8"; end
        3: begin ctl = 32'd0; tag = "R6"; end
        default: begin ctl = C_RD | C_WR; tag = "R6"; end
      endcase
      if (($urandom % 2) == 0) ctl = ctl | C_SEL | (32'($urandom % 6) << 16);
      put_desc(da, ta, len, ctl);
      if (($urandom % 5) == 0) begin
        bad_wr_lo = ta + 64'($urandom % 8); bad_wr_hi = bad_wr_lo;
        bad_rd_lo = bad_wr_lo; bad_rd_hi = bad_wr_lo;
        tag = "R10";
      end
      do_xfer(tag, da, ($urandom % 2) == 1, 1'b0, 1'b1);
    end

    summary();
    $finish;
  end
endmodule